// File: doc/BRIEF.md
# Out-of-Band and Beacon Line-State Generator

This block decides, cycle by cycle, whether one transmit lane sends an out-of-band burst or stays in electrical idle. It runs on the lane's user transmit clock and has two modes, and only one of them is ever in use.

In storage-link mode, a one-cycle start strobe launches a COM sequence. The sequence is a train of bursts, each followed by an idle gap. The type of sequence sets the gap length: the long gap is used for reset/init and the short gap for wake. A 4-bit count sets how many bursts the train has. A line-rate divider code stretches every burst and every gap. When the last gap ends, a one-cycle completion pulse is issued.

In PCIe mode, while the lane sits in the P2 power state, the beacon is driven on any cycle in which electrical idle is released. Surrounding control logic sets the beacon's timing by how it toggles electrical idle.

The output `line_burst` reports the line state: 1 means burst, 0 means idle. A serializer downstream turns that into line activity. All pins are plain control and status. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `oob_beacon_gen`

## Requirements
- R1: In storage-link mode (`mode_pcie`=0), a start strobe is accepted at a clock edge when `pwr_down`=00, `elec_idle`=1 and `com_busy`=0. In the cycle after that edge, `line_burst` and `com_busy` are both 1.
- R2: Each burst lasts BURST_BASE × D cycles. The `div_sel` code gives D: 00 gives 1, 01 gives 2, and 10 or 11 gives 4. With the default parameters, a burst is 4, 8 or 16 cycles.
- R3: After each burst the line is idle for a gap. With `com_type`=0 (reset/init) the gap is RESET_GAP_BASE × D cycles, which is 12 × D by default. With `com_type`=1 (wake) the gap is WAKE_GAP_BASE × D cycles, which is 4 × D by default.
- R4: `burst_num` values 1 to 15 give that many bursts. The value 0 gives 16 bursts.
- R5: `com_type`, `burst_num` and `div_sel` are captured at the edge that accepts the strobe. Changing them later has no effect on the running sequence.
- R6: `com_done` is 1 for exactly one cycle: the cycle right after the last gap ends. In that same cycle `com_busy` and `line_burst` are 0.
- R7: A start strobe has no effect on the sequence or on the outputs in any of these cases: during a running sequence, while `elec_idle`=0, while `pwr_down`≠00, or while `mode_pcie`=1.
- R8: In PCIe mode, `line_burst` in the cycle after an edge equals 1 exactly when, at that edge, `pwr_down`=11 and `elec_idle`=0.
- R9: An edge with `mode_pcie`=1 ends any running sequence. From the next cycle, `com_busy`=0, and `com_done` is never raised for that sequence.
- R10: While reset is asserted, and in the first cycle after it, `line_burst`, `com_busy` and `com_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | User transmit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_pcie | input | 1 | 0 selects storage-link COM signaling, 1 selects PCIe beacon |
| pwr_down | input | 2 | Lane power state: 00 active, 11 P2 |
| elec_idle | input | 1 | Electrical idle request |
| com_start | input | 1 | One-cycle strobe that launches a COM sequence |
| com_type | input | 1 | 0 selects reset/init, 1 selects wake |
| burst_num | input | 4 | Burst count (0 means 16) |
| div_sel | input | 2 | Line-rate divider code |
| line_burst | output | 1 | 1 means burst on the line, 0 means idle |
| com_busy | output | 1 | A COM sequence is running |
| com_done | output | 1 | One-cycle completion pulse |

## Verification
The properties assume that `mode_pcie` changes only through the abort path of R9. They also assume that the sequence registers start from reset. They check the shape of `com_done`, the link between burst output and busy in storage-link mode, and the abort rule. They do not check exact burst lengths. The stimulus keeps within these assumptions as follows. Every strobe is driven for exactly one edge, from the falling clock edge. The mode is switched only while no sequence is running, or on purpose to exercise the abort. The configuration pins are scrambled right after each acceptance, so that any late sampling would show up in the measured waveform.

// File: rtl/oob_pkg.sv
package oob_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_BURST = 2'd1,
    SEQ_GAP   = 2'd2
  } seq_state_t;

  localparam logic [1:0] PD_ACTIVE = 2'b00;
  localparam logic [1:0] PD_P2     = 2'b11;

  // divider code -> left shift applied to every base length
  function automatic logic [1:0] div_shift(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd0;
      2'b01:   return 2'd1;
      default: return 2'd2;
    endcase
  endfunction

endpackage

// File: rtl/oob_len_calc.sv
module oob_len_calc #(
  parameter int BURST_BASE     = 4,
  parameter int RESET_GAP_BASE = 12,
  parameter int WAKE_GAP_BASE  = 4,
  parameter int LEN_W          = 6
) (
  input  logic             type_i,
  input  logic [1:0]       shift_i,
  output logic [LEN_W-1:0] burst_len_o,
  output logic [LEN_W-1:0] gap_len_o
);

  localparam logic [LEN_W-1:0] BURST_L = LEN_W'(BURST_BASE);
  localparam logic [LEN_W-1:0] RGAP_L  = LEN_W'(RESET_GAP_BASE);
  localparam logic [LEN_W-1:0] WGAP_L  = LEN_W'(WAKE_GAP_BASE);

  always_comb begin
    burst_len_o = BURST_L << shift_i;
    gap_len_o   = (type_i ? WGAP_L : RGAP_L) << shift_i;
  end

endmodule

// File: rtl/oob_com_seq.sv
module oob_com_seq
  import oob_pkg::*;
#(
  parameter int BURST_BASE     = 4,
  parameter int RESET_GAP_BASE = 12,
  parameter int WAKE_GAP_BASE  = 4,
  parameter int LEN_W          = 6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       abort_i,
  input  logic       accept_i,
  input  logic       type_i,
  input  logic [3:0] count_i,
  input  logic [1:0] shift_i,
  output logic       burst_o,
  output logic       busy_o,
  output logic       done_o
);

  seq_state_t       state_q;
  logic [LEN_W-1:0] cnt_q;
  logic [3:0]       left_q;
  logic             type_q;
  logic [1:0]       shift_q;
  logic             done_q;

  logic [LEN_W-1:0] burst_len;
  logic [LEN_W-1:0] gap_len;
  logic [LEN_W-1:0] first_len;
  logic             cnt_end;

  // lengths of the running sequence come from captured settings
  oob_len_calc #(
    .BURST_BASE    (BURST_BASE),
    .RESET_GAP_BASE(RESET_GAP_BASE),
    .WAKE_GAP_BASE (WAKE_GAP_BASE),
    .LEN_W         (LEN_W)
  ) u_run_len (
    .type_i     (type_q),
    .shift_i    (shift_q),
    .burst_len_o(burst_len),
    .gap_len_o  (gap_len)
  );

  // first burst length comes from the settings at acceptance
  logic [LEN_W-1:0] unused_gap;
  oob_len_calc #(
    .BURST_BASE    (BURST_BASE),
    .RESET_GAP_BASE(RESET_GAP_BASE),
    .WAKE_GAP_BASE (WAKE_GAP_BASE),
    .LEN_W         (LEN_W)
  ) u_first_len (
    .type_i     (type_i),
    .shift_i    (shift_i),
    .burst_len_o(first_len),
    .gap_len_o  (unused_gap)
  );

  assign cnt_end = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      left_q  <= '0;
      type_q  <= 1'b0;
      shift_q <= 2'd0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (abort_i) begin
        state_q <= SEQ_IDLE;
        cnt_q   <= '0;
      end else begin
        case (state_q)
          SEQ_IDLE: begin
            if (accept_i) begin
              state_q <= SEQ_BURST;
              cnt_q   <= first_len - 1'b1;
              left_q  <= count_i - 4'd1;   // 0 wraps to 15: sixteen bursts
              type_q  <= type_i;
              shift_q <= shift_i;
            end
          end
          SEQ_BURST: begin
            if (cnt_end) begin
              state_q <= SEQ_GAP;
              cnt_q   <= gap_len - 1'b1;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          SEQ_GAP: begin
            if (cnt_end) begin
              if (left_q == 4'd0) begin
                state_q <= SEQ_IDLE;
                done_q  <= 1'b1;
              end else begin
                state_q <= SEQ_BURST;
                cnt_q   <= burst_len - 1'b1;
                left_q  <= left_q - 4'd1;
              end
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          default: state_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign burst_o = (state_q == SEQ_BURST);
  assign busy_o  = (state_q != SEQ_IDLE);
  assign done_o  = done_q;

endmodule

// File: rtl/oob_beacon.sv
module oob_beacon
  import oob_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       enable_i,
  input  logic       elec_idle_i,
  input  logic [1:0] pd_i,
  output logic       beacon_o
);

  logic beacon_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) beacon_q <= 1'b0;
    else        beacon_q <= enable_i && (pd_i == PD_P2) && !elec_idle_i;
  end

  assign beacon_o = beacon_q;

endmodule

// File: rtl/oob_beacon_gen.sv
module oob_beacon_gen
  import oob_pkg::*;
#(
  parameter int BURST_BASE     = 4,
  parameter int RESET_GAP_BASE = 12,
  parameter int WAKE_GAP_BASE  = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       mode_pcie,
  input  logic [1:0] pwr_down,
  input  logic       elec_idle,
  input  logic       com_start,
  input  logic       com_type,
  input  logic [3:0] burst_num,
  input  logic [1:0] div_sel,
  output logic       line_burst,
  output logic       com_busy,
  output logic       com_done
);

  localparam int MAX_BASE = (RESET_GAP_BASE > WAKE_GAP_BASE)
                          ? ((RESET_GAP_BASE > BURST_BASE) ? RESET_GAP_BASE : BURST_BASE)
                          : ((WAKE_GAP_BASE > BURST_BASE) ? WAKE_GAP_BASE : BURST_BASE);
  localparam int LEN_W = $clog2(MAX_BASE * 4 + 1);

  logic accept;
  logic seq_burst;
  logic seq_busy;
  logic seq_done;
  logic beacon;

  assign accept = com_start && !mode_pcie && elec_idle &&
                  (pwr_down == PD_ACTIVE) && !seq_busy;

  oob_com_seq #(
    .BURST_BASE    (BURST_BASE),
    .RESET_GAP_BASE(RESET_GAP_BASE),
    .WAKE_GAP_BASE (WAKE_GAP_BASE),
    .LEN_W         (LEN_W)
  ) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .abort_i (mode_pcie),
    .accept_i(accept),
    .type_i  (com_type),
    .count_i (burst_num),
    .shift_i (div_shift(div_sel)),
    .burst_o (seq_burst),
    .busy_o  (seq_busy),
    .done_o  (seq_done)
  );

  oob_beacon u_beacon (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable_i   (mode_pcie),
    .elec_idle_i(elec_idle),
    .pd_i       (pwr_down),
    .beacon_o   (beacon)
  );

  assign line_burst = mode_pcie ? beacon : seq_burst;
  assign com_busy   = seq_busy;
  assign com_done   = seq_done;

endmodule

// File: rtl/oob_beacon_gen_chk.sv
module oob_beacon_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic mode_pcie,
  input logic line_burst,
  input logic com_busy,
  input logic com_done
);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    com_done |=> !com_done);  // R6

  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    com_done |-> (!com_busy && $past(com_busy)));  // R6

  AST_SATA_BURST_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pcie && line_burst) |-> com_busy);  // R1

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_pcie) |-> !com_busy);  // R9

  AST_ABORT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(mode_pcie) |-> !com_done);  // R9

endmodule

bind oob_beacon_gen oob_beacon_gen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mode_pcie (mode_pcie),
  .line_burst(line_burst),
  .com_busy  (com_busy),
  .com_done  (com_done)
);

// File: tb/oob_beacon_gen_test.sv
module oob_beacon_gen_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_pcie = 1'b0;
  logic [1:0] pwr_down = 2'b00;
  logic       elec_idle = 1'b1;
  logic       com_start = 1'b0;
  logic       com_type = 1'b0;
  logic [3:0] burst_num = 4'd1;
  logic [1:0] div_sel = 2'b00;
  logic       line_burst, com_busy, com_done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  oob_beacon_gen uut (
    .clk(clk), .rst_n(rst_n), .mode_pcie(mode_pcie), .pwr_down(pwr_down),
    .elec_idle(elec_idle), .com_start(com_start), .com_type(com_type),
    .burst_num(burst_num), .div_sel(div_sel), .line_burst(line_burst),
    .com_busy(com_busy), .com_done(com_done)
  );

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int dfac(logic [1:0] d);
    return (d == 2'b00) ? 1 : (d == 2'b01) ? 2 : 4;
  endfunction

  // outputs packed as {line_burst, busy, done}
  function automatic int outs();
    return {29'd0, line_burst, com_busy, com_done};
  endfunction

  // launch and trace a whole sequence; mid >= 0 injects a strobe in that cycle
  task automatic run_seq(bit typ, logic [1:0] ds, logic [3:0] num, int mid);
    int b, g, p, n, t, bad_cyc, bad_act, bad_exp;
    b = 4 * dfac(ds);
    g = (typ ? 4 : 12) * dfac(ds);
    p = b + g;
    n = (num == 4'd0) ? 16 : num;
    t = n * p;
    bad_cyc = -1; bad_act = 0; bad_exp = 0;
    @(negedge clk);
    com_type = typ; div_sel = ds; burst_num = num; com_start = 1'b1;
    @(negedge clk);
    com_start = 1'b0;
    com_type = ~typ; div_sel = ds ^ 2'b01; burst_num = num + 4'd5;  // R5 scramble
    for (int i = 0; i < t; i++) begin
      int e;
      e = (((i % p) < b) ? 4 : 0) + 2;
      if (outs() != e && bad_cyc < 0) begin
        bad_cyc = i; bad_act = outs(); bad_exp = e;
      end
      if (i == mid) com_start = 1'b1;   // R7 strobe while busy
      @(negedge clk);
      com_start = 1'b0;
    end
    chk("R2 R3 R4 R5", $sformatf("trace type=%0d div=%0d num=%0d cyc=%0d", typ, ds, num, bad_cyc),
        bad_act, bad_exp);
    chk("R6", "done cycle {line,busy,done}", outs(), 1);
    @(negedge clk);
    chk("R6", "after done {line,busy,done}", outs(), 0);
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 3);
    @(negedge clk);
    chk("R10", "in reset {line,busy,done}", outs(), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10", "after reset {line,busy,done}", outs(), 0);

    // R1: acceptance raises burst and busy in the next cycle
    @(negedge clk);
    com_type = 1'b1; div_sel = 2'b00; burst_num = 4'd1; com_start = 1'b1;
    @(negedge clk);
    com_start = 1'b0;
    chk("R1", "cycle after accept {line,busy,done}", outs(), 6);
    repeat (12) @(negedge clk);

    // R7: strobe ignored while elec_idle low, power-down not 00, or PCIe mode
    elec_idle = 1'b0; com_start = 1'b1;
    @(negedge clk);
    com_start = 1'b0;
    chk("R7", "elec_idle low {line,busy,done}", outs(), 0);
    elec_idle = 1'b1; pwr_down = 2'b10; com_start = 1'b1;
    @(negedge clk);
    com_start = 1'b0;
    chk("R7", "power-down 10 {line,busy,done}", outs(), 0);
    pwr_down = 2'b00; mode_pcie = 1'b1; com_start = 1'b1;
    @(negedge clk);
    com_start = 1'b0; mode_pcie = 1'b0;
    chk("R7", "pcie mode {line,busy,done}", outs(), 0);
    @(negedge clk);

    // R2 R3 R4 R5 R6: sweep type x divider x count
    for (int ty = 0; ty < 2; ty++)
      for (int d = 0; d < 3; d++)
        for (int nb = 0; nb < 16; nb++)
          run_seq(ty[0], d[1:0], nb[3:0], -1);
    run_seq(1'b0, 2'b11, 4'd2, -1);         // R2 code 11 acts as 4
    run_seq(1'b0, 2'b01, 4'd3, 5);          // R7 strobe mid-burst
    run_seq(1'b1, 2'b00, 4'd2, 6);          // R7 strobe mid-gap

    // R9: abort by switching to PCIe mode mid-sequence
    @(negedge clk);
    com_type = 1'b0; div_sel = 2'b01; burst_num = 4'd4; com_start = 1'b1;
    @(negedge clk);
    com_start = 1'b0;
    repeat (3) @(negedge clk);
    mode_pcie = 1'b1;                      // elec_idle=1, pd 00: no beacon
    @(negedge clk);
    chk("R9", "after abort {line,busy,done}", outs(), 0);
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 300; i++) begin
        @(negedge clk);
        if (com_done) seen++;
      end
      chk("R9", "done pulses after abort", seen, 0);
    end

    // R8: beacon follows P2 and elec_idle one cycle later
    for (int pd = 0; pd < 4; pd++)
      for (int ei = 0; ei < 2; ei++) begin
        pwr_down = pd[1:0]; elec_idle = ei[0];
        @(negedge clk);
        chk("R8", $sformatf("beacon pd=%0d ei=%0d", pd, ei), int'(line_burst),
            (pd == 3 && ei == 0) ? 1 : 0);
      end
    pwr_down = 2'b11;
    for (int i = 0; i < 10; i++) begin
      elec_idle = (i % 3) == 0;
      @(negedge clk);
      chk("R8", $sformatf("beacon toggle step %0d", i), int'(line_burst),
          ((i % 3) == 0) ? 0 : 1);
    end
    elec_idle = 1'b1; pwr_down = 2'b00;
    @(negedge clk);
    mode_pcie = 1'b0;
    @(negedge clk);
    chk("R8", "back to storage mode idle {line,busy,done}", outs(), 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule